// File: doc/BRIEF.md
# Serial Baud Rate Generator

This block derives the timing strobes for an asynchronous serial port from the bus clock. Software programs a 13-bit divisor, an infrared mode flag and a narrow-pulse select through two byte-wide registers on an 8-bit register bus. The block then produces two one-cycle strobes. The oversample strobe runs at sixteen times the bit rate, and the bit strobe marks every sixteenth oversample strobe.

The register holding the upper divisor bits, the infrared flag and the pulse select is double-buffered. A write to it is only staged. The staged value takes effect together with the lower divisor byte when the lower register is written, so a 16-bit divisor update is atomic.

In infrared mode the oversample period is doubled and divisor bit 0 is dropped. The generator stays quiet after reset until the transmitter or the receiver is enabled for the first time. It also stops whenever the effective divisor is zero.

Top module: `baud_gen_top`

## Requirements
- R1: Register address 0 (upper) reads as {infrared enable [7], pulse select [6:5], divisor bits 12:8 [4:0]}. Address 1 (lower) reads as divisor bits 7:0. After reset the upper register reads 0x00 and the lower register reads 0x04.
- R2: A write to the upper register only loads a staging byte. The upper readback, `ir_en_o` and `pulse_sel_o` keep their previous values until the next lower-register write.
- R3: A write to the lower register makes the staged upper byte and the new lower byte active in the same cycle. `pulse_sel_o` exports bits [6:5] of the active upper byte: 00 = 1/16, 01 = 1/32, 10 = 1/4 and 11 = 3/16 of a bit time.
- R4: While `map_sel_i` is 1, register reads return 0x00 and register writes change neither the staging byte nor the active registers.
- R5: After reset no strobe is produced until `tx_en_i` or `rx_en_i` has been 1 in at least one clock. Once started, the generator keeps running after both enables return to 0.
- R6: With infrared disabled, the oversample strobe repeats every D clocks, where D is the full 13-bit divisor.
- R7: With infrared enabled, the oversample strobe repeats every 2 x D[12:1] clocks, and divisor bit 0 has no effect.
- R8: `bit_tick_o` is asserted only together with `os_tick_o`, on every 16th oversample strobe, which gives a period of 16 times the oversample period.
- R9: No strobe is produced while the effective divisor is zero: D = 0 with infrared off, or D[12:1] = 0 with infrared on.
- R10: A lower-register write clears both divide counters. This takes precedence over a strobe in the same cycle, so the next oversample strobe comes one new period after the write and the next bit strobe comes 16 new periods after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| map_sel_i | input | 1 | Register map select; the registers are visible only when this is 0 |
| reg_sel_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 1 | 0 = upper register, 1 = lower register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data (combinational) |
| tx_en_i | input | 1 | Transmitter enable |
| rx_en_i | input | 1 | Receiver enable |
| os_tick_o | output | 1 | Oversample strobe, one clock wide |
| bit_tick_o | output | 1 | Bit-rate strobe, one clock wide |
| ir_en_o | output | 1 | Active infrared enable |
| pulse_sel_o | output | 2 | Active narrow-pulse select |

## Verification
A divisor commit from a lower-register write can land in the same clock as an oversample counter wrap, which also advances the bit counter. The bench provokes this by waiting until it sees the oversample strobe and then driving the lower write so that it is sampled on that wrapping edge. It then counts clocks to the next oversample strobe and to the next bit strobe. A correct design gives exactly one and sixteen new periods. If the bit counter were allowed to advance on the colliding strobe, the bit strobe would arrive one oversample period early.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int unsigned BUS_W = 8;

  typedef enum logic [1:0] {
    PULSE_1_16 = 2'b00,
    PULSE_1_32 = 2'b01,
    PULSE_1_4  = 2'b10,
    PULSE_3_16 = 2'b11
  } pulse_sel_e;
endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import baud_gen_pkg::*;
#(
  parameter int unsigned DIV_W   = 13,
  parameter logic [7:0]  RST_LOW = 8'h04
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             map_sel_i,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             ir_en_o,
  output pulse_sel_e       pulse_sel_o,
  output logic [DIV_W-1:0] div_o,
  output logic             commit_o
);
  localparam int unsigned HI_W = DIV_W - BUS_W;

  logic [BUS_W-1:0] stage_q, hi_q, lo_q;
  logic             acc_ok, wr_hi, wr_lo;

  assign acc_ok = sel_i & ~map_sel_i;
  assign wr_hi  = acc_ok & we_i & ~addr_i;
  assign wr_lo  = acc_ok & we_i & addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      hi_q    <= '0;
      lo_q    <= RST_LOW;
    end else begin
      if (wr_hi) stage_q <= wdata_i;
      if (wr_lo) begin
        hi_q <= stage_q;
        lo_q <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (acc_ok && !we_i) rdata_o = addr_i ? lo_q : hi_q;
  end

  assign ir_en_o     = hi_q[7];
  assign pulse_sel_o = pulse_sel_e'(hi_q[6:5]);
  assign div_o       = {hi_q[HI_W-1:0], lo_q};
  assign commit_o    = wr_lo;

  a_r4_map_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_sel_i |=> ($stable(stage_q) && $stable(hi_q) && $stable(lo_q)));
  a_r2_hi_staged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi |=> $stable(hi_q));
  a_r3_commit_copies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo |=> (hi_q == $past(stage_q)));
endmodule

// File: rtl/baud_ctrl.sv
module baud_ctrl #(
  parameter int unsigned DIV_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic             rx_en_i,
  input  logic             ir_en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             running_o,
  output logic [DIV_W-1:0] period_o
);
  logic started_q;

  // sticky: first enable starts the generator for good
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  started_q <= 1'b0;
    else if (tx_en_i || rx_en_i)  started_q <= 1'b1;
  end

  // infrared: bit 0 dropped, period doubled
  assign period_o  = ir_en_i ? {div_i[DIV_W-1:1], 1'b0} : div_i;
  assign running_o = started_q && (period_o != '0);

  a_r5_sticky_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |=> started_q);
endmodule

// File: rtl/baud_div.sv
module baud_div #(
  parameter int unsigned DIV_W    = 13,
  parameter int unsigned OS_RATIO = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             reload_i,
  input  logic [DIV_W-1:0] period_i,
  output logic             os_tick_o,
  output logic             bit_tick_o
);
  logic [DIV_W-1:0] os_cnt_q;

  assign os_tick_o = run_i && (os_cnt_q == period_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  os_cnt_q <= '0;
    else if (!run_i || reload_i)  os_cnt_q <= '0;
    else if (os_tick_o)           os_cnt_q <= '0;
    else                          os_cnt_q <= os_cnt_q + DIV_W'(1);
  end

  generate
    if (OS_RATIO > 1) begin : g_bit_cnt
      localparam int unsigned BC_W = $clog2(OS_RATIO);
      logic [BC_W-1:0] bit_cnt_q;

      assign bit_tick_o = os_tick_o && (bit_cnt_q == BC_W'(OS_RATIO - 1));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  bit_cnt_q <= '0;
        else if (!run_i || reload_i)  bit_cnt_q <= '0;
        else if (bit_tick_o)          bit_cnt_q <= '0;
        else if (os_tick_o)           bit_cnt_q <= bit_cnt_q + BC_W'(1);
      end

      a_r10_bit_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reload_i |=> (bit_cnt_q == '0));
    end else begin : g_bit_pass
      assign bit_tick_o = os_tick_o;
    end
  endgenerate

  a_r8_bit_on_os: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> os_tick_o);
  a_r10_os_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (os_cnt_q == '0));
  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (os_cnt_q < period_i));
endmodule

// File: rtl/baud_gen_top.sv
module baud_gen_top
  import baud_gen_pkg::*;
#(
  parameter int unsigned DIV_W    = 13,
  parameter int unsigned OS_RATIO = 16,
  parameter logic [7:0]  RST_LOW  = 8'h04
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             map_sel_i,
  input  logic             reg_sel_i,
  input  logic             reg_we_i,
  input  logic             reg_addr_i,
  input  logic [BUS_W-1:0] reg_wdata_i,
  output logic [BUS_W-1:0] reg_rdata_o,
  input  logic             tx_en_i,
  input  logic             rx_en_i,
  output logic             os_tick_o,
  output logic             bit_tick_o,
  output logic             ir_en_o,
  output logic [1:0]       pulse_sel_o
);
  logic             ir_en, commit, running;
  pulse_sel_e       pulse_sel;
  logic [DIV_W-1:0] div, period;

  baud_regs #(.DIV_W(DIV_W), .RST_LOW(RST_LOW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .map_sel_i   (map_sel_i),
    .sel_i       (reg_sel_i),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .ir_en_o     (ir_en),
    .pulse_sel_o (pulse_sel),
    .div_o       (div),
    .commit_o    (commit)
  );

  baud_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_en_i   (tx_en_i),
    .rx_en_i   (rx_en_i),
    .ir_en_i   (ir_en),
    .div_i     (div),
    .running_o (running),
    .period_o  (period)
  );

  baud_div #(.DIV_W(DIV_W), .OS_RATIO(OS_RATIO)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (running),
    .reload_i   (commit),
    .period_i   (period),
    .os_tick_o  (os_tick_o),
    .bit_tick_o (bit_tick_o)
  );

  assign ir_en_o     = ir_en;
  assign pulse_sel_o = pulse_sel;

  a_r9_no_tick_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ir_en ? (div[DIV_W-1:1] == '0) : (div == '0))) |-> !os_tick_o);
endmodule

// File: tb/test_baud_gen_top.sv
`timescale 1ns/1ps
module test_baud_gen_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       map_sel = 1'b0, sel = 1'b0, we = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tx_en = 1'b0, rx_en = 1'b0;
  logic       os_tick, bit_tick, ir_en;
  logic [1:0] pulse_sel;

  baud_gen_top i_baud_gen_top (
    .clk_i(clk), .rst_ni(rst_n), .map_sel_i(map_sel),
    .reg_sel_i(sel), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .tx_en_i(tx_en), .rx_en_i(rx_en),
    .os_tick_o(os_tick), .bit_tick_o(bit_tick),
    .ir_en_o(ir_en), .pulse_sel_o(pulse_sel)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard
  int    q_os[$], q_bit[$];
  string t_os[$], t_bit[$];
  bit    arm_os = 1'b0, arm_bit = 1'b0;
  int    last_os = 0, last_bit = 0, seen_os = 0;

  always @(negedge clk) begin
    if (os_tick) begin
      seen_os++;
      if (arm_os && q_os.size() > 0) chk(t_os.pop_front(), cyc - last_os, q_os.pop_front());
      last_os = cyc;
      arm_os  = 1'b1;
    end
    if (bit_tick) begin
      if (arm_bit && q_bit.size() > 0) chk(t_bit.pop_front(), cyc - last_bit, q_bit.pop_front());
      last_bit = cyc;
      arm_bit  = 1'b1;
    end
  end

  task automatic sync();
    q_os.delete(); t_os.delete(); q_bit.delete(); t_bit.delete();
    arm_os = 1'b0; arm_bit = 1'b0;
  endtask

  task automatic expect_run(string tag, int p, int n);
    sync();
    for (int i = 0; i < n; i++) begin
      q_os.push_back(p); t_os.push_back({tag, " os period"});
    end
    q_bit.push_back(16 * p); t_bit.push_back({tag, " R8 bit period"});
    repeat (34 * p + 20) @(negedge clk);
    chk({tag, " scoreboard drained"}, q_os.size() + q_bit.size(), 0);
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic quiet(string tag, int cycles);
    int s;
    sync();
    s = seen_os;
    repeat (cycles) @(negedge clk);
    chk(tag, seen_os - s, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int n, n_os;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1'b0, d); chk("R1 upper reset", d, 8'h00);
    rd(1'b1, d); chk("R1 lower reset", d, 8'h04);
    chk("R1 ir reset", ir_en, 0);
    chk("R1 pulse reset", pulse_sel, 0);

    // R5 idle before any enable
    wr(1'b0, 8'h00); wr(1'b1, 8'h03);
    quiet("R5 idle before enable", 100);
    @(negedge clk); rx_en = 1'b1;
    @(negedge clk); rx_en = 1'b0;
    expect_run("R5 R6 div3", 3, 4);
    wr(1'b1, 8'h07);
    expect_run("R6 div7", 7, 4);

    // R2 staging, R3 commit
    wr(1'b0, 8'h01);
    rd(1'b0, d); chk("R2 upper staged", d, 8'h00);
    wr(1'b1, 8'h00);
    rd(1'b0, d); chk("R3 upper committed", d, 8'h01);
    expect_run("R6 div256", 256, 2);

    wr(1'b0, 8'h60);
    chk("R2 pulse held", pulse_sel, 0);
    wr(1'b1, 8'h05);
    chk("R3 pulse 3/16", pulse_sel, 3);
    chk("R3 ir off", ir_en, 0);
    expect_run("R6 div5", 5, 4);
    for (int p = 0; p < 4; p++) begin
      wr(1'b0, {1'b0, 2'(p), 5'b0});
      wr(1'b1, 8'h05);
      chk("R3 pulse encode", pulse_sel, p);
    end

    // R7 infrared
    wr(1'b0, 8'h80); wr(1'b1, 8'h07);
    chk("R7 ir on", ir_en, 1);
    expect_run("R7 div7 ir", 6, 4);
    wr(1'b1, 8'h06);
    expect_run("R7 div6 ir", 6, 4);
    wr(1'b1, 8'h0B);
    expect_run("R7 div11 ir", 10, 3);

    // R9 zero effective divisor
    wr(1'b1, 8'h01);
    quiet("R9 ir div1 stops", 300);
    wr(1'b0, 8'h00); wr(1'b1, 8'h00);
    quiet("R9 div0 stops", 300);
    wr(1'b1, 8'h02);
    expect_run("R5 R9 resume", 2, 4);

    // R4 map select
    map_sel = 1'b1;
    wr(1'b0, 8'hFF); wr(1'b1, 8'hFF);
    rd(1'b0, d); chk("R4 upper hidden", d, 0);
    rd(1'b1, d); chk("R4 lower hidden", d, 0);
    map_sel = 1'b0;
    rd(1'b1, d); chk("R4 lower unchanged", d, 8'h02);
    rd(1'b0, d); chk("R4 upper unchanged", d, 8'h00);
    expect_run("R4 period unchanged", 2, 4);

    // R10 commit in the same cycle as an oversample wrap
    wr(1'b1, 8'h05);
    sync();
    repeat (12) @(negedge clk);
    do @(negedge clk); while (!os_tick);
    sel = 1'b1; we = 1'b1; addr = 1'b1; wdata = 8'h09;
    n = 0; n_os = 0;
    do begin
      @(negedge clk);
      sel = 1'b0; we = 1'b0;
      n++;
      if (os_tick && n_os == 0) n_os = n;
    end while (!bit_tick && n < 1000);
    chk("R10 first os after collide", n_os, 9);
    chk("R10 first bit after collide", n, 144);

    finish_run();
  end
endmodule